// File: doc/BRIEF.md
# Legacy Shadow Memory Route Decoder

This block sits between the processor or bus address path and the memory controller. It decides, for every access below the 1 MB line, whether the access is served by internal DRAM or passed on to the external bus. Part of that space is cut into segments of uneven size. Each segment carries a 2-bit attribute, so reads and writes can be routed on their own. A firmware image can then be copied into DRAM and run from there ("shadowed"), or an option ROM can be read externally while its DRAM copy is being written.

Software programs seven attribute registers and one video-window control register through a byte-wide port. Each register is selected by a 3-bit selector. The access side is purely combinational. It takes an address and a read/write flag and returns a single route bit, which is computed from the registered configuration. A parameter picks one of two reset personalities: the bus-side instance or the memory-side instance.

Top module: `shadow_route_decoder`

## Requirements
- R1: A segment attribute has two bits. Bit 0 set routes reads internal, and bit 1 set routes writes internal. Value 0 is all external, 1 is read-internal/write-external, 2 is read-external/write-internal and 3 is all internal.
- R2: Selector 0 is attribute register 0. Its bits [1:0] govern 0x80000–0x9FFFF and its bits [5:4] govern 0xF0000–0xFFFFF.
- R3: Selectors 1 to 6 are attribute registers 1 to 6. Register k governs two 16 KB segments: bits [1:0] cover the one at 0xC0000 + (2k−2)·0x4000, and bits [5:4] cover the next one up. Together they span 0xC0000–0xEFFFF.
- R4: Reading an attribute register returns the written byte ANDed with 0x33. Selector 7 is the video-window control register, and reading it returns the written byte ANDed with 0x02.
- R5: A write replaces both nibbles of the selected register. A segment whose 2-bit field is unchanged by the write keeps its route, and a changed field affects only its own segment.
- R6: The window 0xA0000–0xBFFFF routes reads and writes internal when bit 1 of the video-window control register is set, and external when it is clear.
- R7: Addresses below 0x80000, and addresses at or above 0x100000 (all upper address bits checked), route internal.
- R8: After reset, the bus-side instance (BUS_SIDE=1) reads back 0x30 on selector 0, 0x33 on selectors 1–6 and 0x02 on selector 7. The memory-side instance reads back 0x03, 0x00 and 0x00.
- R9: `bios_shadowed` equals bit 4 of attribute register 0.
- R10: `route_internal` follows `acc_addr` and `acc_write` in the same cycle. A register write takes effect at the rising clock edge that accepts it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe, sampled at the rising edge |
| cfg_sel | input | 3 | Register selector: 0–6 attribute registers, 7 video-window control |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register (combinational) |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| route_internal | output | 1 | 1 routes the access to internal DRAM, 0 to the external bus |
| bios_shadowed | output | 1 | Status flag that mirrors attribute register 0 bit 4 |

## Verification
A corrupted attribute field shows up on `route_internal` in the same cycle as an access to its segment. It appears only for the access direction whose bit is wrong, so every segment is probed with both reads and writes. A wrong segment decode moves a route to a neighbouring segment, which is why adjacent segments are programmed with different attributes and probed at their first and last bytes. Register state that is not on the access path, such as masking and reset values, becomes visible one cycle after a write or reset through `cfg_rdata` and `bios_shadowed`.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    // Register file geometry
    localparam int ATTR_REGS = 7;
    localparam int SEGS      = 2 * ATTR_REGS;
    localparam int SEG_IDX_W = $clog2(SEGS);
    localparam int SEL_W     = $clog2(ATTR_REGS + 1);
    localparam logic [SEL_W-1:0] VID_SEL = SEL_W'(ATTR_REGS);

    // Read-back masks
    localparam logic [7:0] ATTR_MASK = 8'h33;
    localparam logic [7:0] VID_MASK  = 8'h02;

    // Attribute: bit 0 read internal, bit 1 write internal
    typedef logic [1:0] attr_t;

    typedef enum logic [1:0] {
        REGION_DEFAULT = 2'd0,
        REGION_VIDEO   = 2'd1,
        REGION_SEG     = 2'd2
    } region_e;

    typedef struct packed {
        region_e               region;
        logic [SEG_IDX_W-1:0]  seg;
    } hit_t;

    // seg[2r] is the low nibble of register r, seg[2r+1] the high nibble
    typedef struct packed {
        attr_t [SEGS-1:0] seg;
        logic             vid_int;
    } cfg_t;

    function automatic cfg_t reset_cfg(input bit bus_side);
        cfg_t c;
        for (int i = 0; i < SEGS; i++) begin
            if (bus_side) c.seg[i] = (i == 0) ? 2'd0 : 2'd3;
            else          c.seg[i] = (i == 0) ? 2'd3 : 2'd0;
        end
        c.vid_int = bus_side;
        return c;
    endfunction

endpackage

// File: rtl/shadow_seg_lookup.sv
module shadow_seg_lookup
    import shadow_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);

    logic above_1m;
    logic unused_addr_lo;

    assign above_1m       = |addr[ADDR_W-1:20];
    assign unused_addr_lo = ^addr[13:0];

    always_comb begin
        hit.region = REGION_DEFAULT;
        hit.seg    = '0;
        if (!above_1m) begin
            unique case (addr[19:16])
                4'h8, 4'h9: begin
                    hit.region = REGION_SEG;
                    hit.seg    = SEG_IDX_W'(0);
                end
                4'hA, 4'hB: begin
                    hit.region = REGION_VIDEO;
                end
                4'hC, 4'hD, 4'hE: begin
                    // 16 KB slices: C0000 -> 2, EC000 -> 13
                    hit.region = REGION_SEG;
                    hit.seg    = SEG_IDX_W'(2) + SEG_IDX_W'(addr[17:14]);
                end
                4'hF: begin
                    hit.region = REGION_SEG;
                    hit.seg    = SEG_IDX_W'(1);
                end
                default: begin
                    hit.region = REGION_DEFAULT;
                end
            endcase
        end
    end

endmodule

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
    import shadow_pkg::*;
#(
    parameter bit BUS_SIDE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output cfg_t             cfg
);

    cfg_t cfg_d, cfg_q;
    cfg_t rst_val;
    logic unused_wdata;

    assign unused_wdata = ^{wdata[7:6], wdata[3:2]};

    generate
        if (BUS_SIDE) begin : g_bus_defaults
            assign rst_val = reset_cfg(1'b1);
        end else begin : g_mem_defaults
            assign rst_val = reset_cfg(1'b0);
        end
    endgenerate

    // Next-state: each nibble field is updated only when its value differs
    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            if (sel == VID_SEL) begin
                cfg_d.vid_int = wdata[1];
            end else begin
                for (int n = 0; n < 2; n++) begin
                    if (wdata[4*n +: 2] != cfg_q.seg[2*int'(sel) + n]) begin
                        cfg_d.seg[2*int'(sel) + n] = wdata[4*n +: 2];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= rst_val;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (sel == VID_SEL) begin
            rdata[1] = cfg_q.vid_int;
        end else begin
            rdata[1:0] = cfg_q.seg[2*int'(sel)];
            rdata[5:4] = cfg_q.seg[2*int'(sel) + 1];
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/shadow_route_mux.sv
module shadow_route_mux
    import shadow_pkg::*;
(
    input  hit_t  hit,
    input  cfg_t  cfg,
    input  logic  is_write,
    output logic  internal
);

    attr_t attr;

    always_comb begin
        attr = 2'd3;
        if (int'(hit.seg) < SEGS) attr = cfg.seg[hit.seg];
    end

    always_comb begin
        unique case (hit.region)
            REGION_VIDEO: internal = cfg.vid_int;
            REGION_SEG:   internal = is_write ? attr[1] : attr[0];
            default:      internal = 1'b1;
        endcase
    end

endmodule

// File: rtl/shadow_route_decoder.sv
module shadow_route_decoder
    import shadow_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter bit BUS_SIDE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              route_internal,
    output logic              bios_shadowed
);

    cfg_t cfg;
    hit_t hit;

    shadow_cfg_regs #(
        .BUS_SIDE (BUS_SIDE)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    shadow_seg_lookup #(
        .ADDR_W (ADDR_W)
    ) u_lookup (
        .addr (acc_addr),
        .hit  (hit)
    );

    shadow_route_mux u_mux (
        .hit      (hit),
        .cfg      (cfg),
        .is_write (acc_write),
        .internal (route_internal)
    );

    // Register 0 high nibble, bit 0 (register bit 4)
    assign bios_shadowed = cfg.seg[1][0];

endmodule

// File: rtl/shadow_route_checker.sv
module shadow_route_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [2:0]        cfg_sel,
    input logic [7:0]        cfg_rdata,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic              route_internal,
    input logic              bios_shadowed
);

    logic in_video;
    assign in_video = (acc_addr[ADDR_W-1:20] == '0) && (acc_addr[19:17] == 3'b101);

    p_high_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|acc_addr[ADDR_W-1:20]) |-> route_internal);

    p_low_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[ADDR_W-1:19] == '0) |-> route_internal);

    p_attr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel != 3'd7) |-> ((cfg_rdata & 8'hCC) == 8'h00));

    p_vid_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 3'd7) |-> ((cfg_rdata & 8'hFD) == 8'h00));

    p_video_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_video && cfg_sel == 3'd7) |-> (route_internal == cfg_rdata[1]));

    p_bios_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 3'd0) |-> (bios_shadowed == cfg_rdata[4]));

    p_hold_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_wr) && $stable(acc_addr) && $stable(acc_write))
        |-> $stable(route_internal));

endmodule

bind shadow_route_decoder shadow_route_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_sel        (cfg_sel),
    .cfg_rdata      (cfg_rdata),
    .acc_addr       (acc_addr),
    .acc_write      (acc_write),
    .route_internal (route_internal),
    .bios_shadowed  (bios_shadowed)
);

// File: tb/shadow_route_decoder_test.sv
module shadow_route_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_write = 1'b0;
    logic [7:0]  rdata_b, rdata_m;
    logic        route_b, route_m, bios_b, bios_m;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    shadow_route_decoder #(.ADDR_W(32), .BUS_SIDE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_b), .acc_addr(acc_addr),
        .acc_write(acc_write), .route_internal(route_b), .bios_shadowed(bios_b));

    shadow_route_decoder #(.ADDR_W(32), .BUS_SIDE(1'b0)) uut_mem (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_m), .acc_addr(acc_addr),
        .acc_write(acc_write), .route_internal(route_m), .bios_shadowed(bios_m));

    // {req[3:0], expected route, write, address}
    // Configuration: r0=21 r1=30 r2=12 r3=01 r4=23 r5=32 r6=10 video off
    localparam int NV = 30;
    localparam logic [37:0] VEC [NV] = '{
        {4'd2, 1'b1, 1'b0, 32'h0008_0000},   // R2 low nibble attr 1
        {4'd2, 1'b0, 1'b1, 32'h0008_0000},
        {4'd2, 1'b1, 1'b0, 32'h0009_FFFF},
        {4'd2, 1'b0, 1'b0, 32'h000F_0000},   // R2 high nibble attr 2
        {4'd2, 1'b1, 1'b1, 32'h000F_0000},
        {4'd2, 1'b1, 1'b1, 32'h000F_FFFF},
        {4'd1, 1'b0, 1'b0, 32'h000C_0000},   // R1 attr 0
        {4'd1, 1'b0, 1'b1, 32'h000C_0000},
        {4'd1, 1'b1, 1'b0, 32'h000C_4000},   // R1 attr 3
        {4'd1, 1'b1, 1'b1, 32'h000C_7FFF},
        {4'd1, 1'b0, 1'b0, 32'h000C_8000},   // R1 attr 2
        {4'd1, 1'b1, 1'b1, 32'h000C_8000},
        {4'd1, 1'b1, 1'b0, 32'h000C_C000},   // R1 attr 1
        {4'd1, 1'b0, 1'b1, 32'h000C_FFFF},
        {4'd3, 1'b1, 1'b0, 32'h000D_0000},   // R3 register 3
        {4'd3, 1'b0, 1'b1, 32'h000D_4000},
        {4'd3, 1'b1, 1'b0, 32'h000D_8000},   // R3 register 4
        {4'd3, 1'b0, 1'b0, 32'h000D_C000},
        {4'd3, 1'b1, 1'b1, 32'h000E_0000},   // R3 register 5
        {4'd3, 1'b1, 1'b1, 32'h000E_4000},
        {4'd3, 1'b0, 1'b0, 32'h000E_8000},   // R3 register 6
        {4'd3, 1'b1, 1'b0, 32'h000E_FFFF},
        {4'd3, 1'b0, 1'b1, 32'h000E_FFFF},
        {4'd6, 1'b0, 1'b0, 32'h000A_0000},   // R6 window off
        {4'd6, 1'b0, 1'b1, 32'h000B_FFFF},
        {4'd7, 1'b1, 1'b0, 32'h0000_0000},   // R7 defaults
        {4'd7, 1'b1, 1'b1, 32'h0007_FFFF},
        {4'd7, 1'b1, 1'b0, 32'h0010_0000},
        {4'd7, 1'b1, 1'b0, 32'h0018_0000},
        {4'd7, 1'b1, 1'b1, 32'hFFFF_FFFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_sel = sel; cfg_wdata = data; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] sel, output logic [7:0] vb, output logic [7:0] vm);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        vb = rdata_b; vm = rdata_m;
    endtask

    task automatic probe(input logic [31:0] a, input logic w, output logic r);
        @(negedge clk);
        acc_addr = a; acc_write = w;
        #1;
        r = route_b;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] vb, vm;
        logic r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R8 reset values, both personalities
        for (int s = 0; s < 8; s++) begin
            rd_reg(3'(s), vb, vm);
            check("R8 bus reset", 32'(vb), (s == 0) ? 32'h30 : (s == 7) ? 32'h02 : 32'h33);
            check("R8 mem reset", 32'(vm), (s == 0) ? 32'h03 : 32'h00);
        end
        check("R9 bus bios flag after reset", 32'(bios_b), 32'd1);
        check("R9 mem bios flag after reset", 32'(bios_m), 32'd0);

        // Program the table configuration
        wr_reg(3'd0, 8'hE1);   // stores 0x21
        wr_reg(3'd1, 8'h30);
        wr_reg(3'd2, 8'h12);
        wr_reg(3'd3, 8'hCD);   // stores 0x01
        wr_reg(3'd4, 8'h23);
        wr_reg(3'd5, 8'h32);
        wr_reg(3'd6, 8'h10);
        wr_reg(3'd7, 8'hFD);   // bit 1 clear

        // R4 masking
        rd_reg(3'd0, vb, vm); check("R4 reg0 mask", 32'(vb), 32'h21);
        rd_reg(3'd3, vb, vm); check("R4 reg3 mask", 32'(vb), 32'h01);
        rd_reg(3'd7, vb, vm); check("R4 video mask", 32'(vb), 32'h00);
        check("R9 bios flag cleared", 32'(bios_b), 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            probe(VEC[i][31:0], VEC[i][32], r);
            if (r !== VEC[i][33]) begin
                errors++;
                $display("FAIL R%0d addr %h wr %0d actual %0d expected %0d",
                         VEC[i][37:34], VEC[i][31:0], VEC[i][32], r, VEC[i][33]);
            end
            checks++;
        end

        // R6 window on
        wr_reg(3'd7, 8'h02);
        probe(32'h000A_0000, 1'b0, r); check("R6 window read", 32'(r), 32'd1);
        probe(32'h000B_0000, 1'b1, r); check("R6 window write", 32'(r), 32'd1);
        rd_reg(3'd7, vb, vm); check("R4 video readback", 32'(vb), 32'h02);

        // R5 only the changed nibble moves
        wr_reg(3'd1, 8'h31);
        probe(32'h000C_0000, 1'b0, r); check("R5 changed low segment", 32'(r), 32'd1);
        probe(32'h000C_0000, 1'b1, r); check("R5 changed low segment write", 32'(r), 32'd0);
        probe(32'h000C_4000, 1'b1, r); check("R5 unchanged high segment", 32'(r), 32'd1);
        probe(32'h000C_8000, 1'b1, r); check("R5 neighbour register", 32'(r), 32'd1);

        // R10 write takes effect at the accepting edge
        probe(32'h000C_8000, 1'b0, r); check("R10 before write", 32'(r), 32'd0);
        @(negedge clk);
        cfg_sel = 3'd2; cfg_wdata = 8'h11; cfg_wr = 1'b1;
        #1 check("R10 not before edge", 32'(route_b), 32'd0);
        @(posedge clk);
        #1 check("R10 after edge", 32'(route_b), 32'd1);
        @(negedge clk) cfg_wr = 1'b0;
        acc_write = 1'b1;
        #1 check("R10 same-cycle direction change", 32'(route_b), 32'd0);

        // R9 flag follows register 0 bit 4
        wr_reg(3'd0, 8'h10);
        #1 check("R9 bios flag set", 32'(bios_b), 32'd1);
        probe(32'h0008_0000, 1'b0, r); check("R2 low nibble now 0", 32'(r), 32'd0);

        // R8 mid-run reset
        @(negedge clk) rst_n = 1'b0;
        #1;
        rd_reg(3'd5, vb, vm);
        check("R8 bus reset again", 32'(vb), 32'h33);
        check("R8 mem reset again", 32'(vm), 32'h00);
        @(negedge clk) rst_n = 1'b1;
        rd_reg(3'd7, vb, vm); check("R8 video reset", 32'(vb), 32'h02);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule